// File: doc/BRIEF.md
# GPIO Event Detect Interrupt Unit

This block watches up to 54 general-purpose pins and records, per pin, whether a software-selected condition has occurred. Six detect types can be enabled independently for every pin: rising edge, falling edge, high level and low level on the synchronized pin vector, plus rising and falling edges on the raw, unsynchronized pin vector. A detected condition sets a sticky status bit that software clears by writing one to it.

The status bits are gathered into three interrupt lines. Each line covers a fixed contiguous pin range, split at pins 28 and 46. Software programs the unit through a plain 32-bit register bus. Writes are single-cycle and reads are combinational. This is a control path, so it has no valid/ready handshake and no back-pressure. Pins above 31 live in a second word at the base offset plus 4.

Top module: `gpev_unit`

## Requirements
- R1: With the rising-enable bit of a pin set, a 0 to 1 change on `pin_sync` sets that pin's status bit at the next clock edge. A 1 to 0 change does not set it.
- R2: With the falling-enable bit set, a 1 to 0 change on `pin_sync` sets the status bit at the next edge. A 0 to 1 change does not set it.
- R3: With both the rising and the falling enable set for a pin, each edge in either direction sets its status bit.
- R4: With the high-level enable set, the status bit is set on every edge at which the pin is high. A clear written while the level persists therefore leaves the bit set.
- R5: With the low-level enable set, the status bit is set on every edge at which the pin is low.
- R6: The raw-rise and raw-fall enables detect 0 to 1 and 1 to 0 changes on `pin_raw`, sampled once per clock, and set the status bit at the next edge.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: When a set condition and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R9: Each `irq_o` line is the OR of the status bits in its range. Bit 0 covers pins 0 to 27, bit 1 covers pins 28 to 45, and bit 2 covers pins 46 to 53.
- R10: Register byte addresses:
  - status: 0x40
  - rising enable: 0x4C
  - falling enable: 0x58
  - high enable: 0x64
  - low enable: 0x70
  - raw-rise enable: 0x7C
  - raw-fall enable: 0x88

  Pin n sits in bit n%32 of the word at the base plus 4*(n/32). Enables read back as written, and bits above the last pin read 0.
- R11: After reset all enables and status bits are 0 and `irq_o` is 0. Disabling every enable and then writing ones to both status words leaves no bit set and all lines low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_sync | input | NPINS | Pin levels, already synchronized |
| pin_raw | input | NPINS | Pin levels, unsynchronized |
| irq_o | output | 3 | Interrupt lines per pin range |

## Verification
Timing of the results:
- An edge or level applied to a pin shows in the status word and on `irq_o` one rising clock edge later.
- A register write takes effect at the edge it is presented on, so a level condition whose enable was just written appears one edge after that write.
- Read data is combinational.

The bench drives every input on the falling clock edge. It checks results at the falling edge after the rising edge where they become due. For a fresh level enable it waits one further cycle. It also confirms that a value holds across the edges where nothing should change it.

// File: rtl/gpev_pkg.sv
package gpev_pkg;
  localparam int ADDR_W = 8;
  localparam int NTYPES = 6;
  localparam int NLINES = 3;

  // detect type index into the enable array
  localparam int T_RISE  = 0;
  localparam int T_FALL  = 1;
  localparam int T_HIGH  = 2;
  localparam int T_LOW   = 3;
  localparam int T_ARISE = 4;
  localparam int T_AFALL = 5;

  localparam logic [ADDR_W-1:0] STAT_BASE = 8'h40;

  // enable blocks sit 12 bytes apart starting at 0x4C, in type order
  function automatic logic [ADDR_W-1:0] en_base(input int t);
    return 8'h4C + 8'(12 * t);
  endfunction
endpackage

// File: rtl/gpev_regs.sv
module gpev_regs
  import gpev_pkg::*;
#(
  parameter int NPINS = 54
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     bus_wr,
  input  logic [ADDR_W-1:0]                        bus_addr,
  input  logic [31:0]                              bus_wdata,
  output logic [NTYPES-1:0][((NPINS+31)/32)*32-1:0] en_q
);
  localparam int NWORDS = (NPINS + 31) / 32;
  localparam int PADW   = NWORDS * 32;

  function automatic logic [PADW-1:0] valid_mask();
    logic [PADW-1:0] m;
    for (int i = 0; i < PADW; i++) m[i] = (i < NPINS);
    return m;
  endfunction
  localparam logic [PADW-1:0] VALID = valid_mask();

  for (genvar t = 0; t < NTYPES; t++) begin : g_type
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [ADDR_W-1:0] ADDR = en_base(t) + ADDR_W'(4 * w);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          en_q[t][w*32 +: 32] <= '0;
        else if (bus_wr && bus_addr == ADDR)
          en_q[t][w*32 +: 32] <= bus_wdata & VALID[w*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/gpev_detect.sv
module gpev_detect
  import gpev_pkg::*;
#(
  parameter int NPINS = 54
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPINS-1:0]             pin_sync,
  input  logic [NPINS-1:0]             pin_raw,
  input  logic [NTYPES-1:0][NPINS-1:0] en,
  output logic [NPINS-1:0]             set_vec
);
  logic [NPINS-1:0] sync_prev, raw_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev <= '0;
      raw_prev  <= '0;
    end else begin
      sync_prev <= pin_sync;
      raw_prev  <= pin_raw;   // single unsynchronized sample for raw edges
    end
  end

  always_comb begin
    set_vec = (en[T_RISE]  &  pin_sync & ~sync_prev)
            | (en[T_FALL]  & ~pin_sync &  sync_prev)
            | (en[T_HIGH]  &  pin_sync)
            | (en[T_LOW]   & ~pin_sync)
            | (en[T_ARISE] &  pin_raw  & ~raw_prev)
            | (en[T_AFALL] & ~pin_raw  &  raw_prev);
  end
endmodule

// File: rtl/gpev_status.sv
module gpev_status
  import gpev_pkg::*;
#(
  parameter int NPINS   = 54,
  parameter int SPLIT_A = 28,
  parameter int SPLIT_B = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  set_vec,
  input  logic [NPINS-1:0]  clr_vec,
  output logic [NPINS-1:0]  status_q,
  output logic [NLINES-1:0] irq_o
);
  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    localparam int LO = (k == 0) ? 0 : ((k == 1) ? SPLIT_A : SPLIT_B);
    localparam int HI = (k == 0) ? SPLIT_A : ((k == 1) ? SPLIT_B : NPINS);
    assign irq_o[k] = |status_q[HI-1:LO];
  end
endmodule

// File: rtl/gpev_unit.sv
module gpev_unit
  import gpev_pkg::*;
#(
  parameter int NPINS   = 54,
  parameter int SPLIT_A = 28,
  parameter int SPLIT_B = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_sync,
  input  logic [NPINS-1:0]  pin_raw,
  output logic [2:0]        irq_o
);
  localparam int NWORDS = (NPINS + 31) / 32;
  localparam int PADW   = NWORDS * 32;

  logic [NTYPES-1:0][PADW-1:0]  en_q;
  logic [NTYPES-1:0][NPINS-1:0] en_vec;
  logic [NWORDS-1:0]            stat_wr;
  logic [NPINS-1:0]             clr_vec, set_vec, status_q;
  logic [PADW-1:0]              stat_pad;

  gpev_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q)
  );

  for (genvar t = 0; t < NTYPES; t++) begin : g_en
    assign en_vec[t] = en_q[t][NPINS-1:0];
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_sw
    assign stat_wr[w] = bus_wr && (bus_addr == STAT_BASE + ADDR_W'(4 * w));
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_clr
    assign clr_vec[i] = stat_wr[i/32] & bus_wdata[i%32];
  end

  gpev_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .pin_raw(pin_raw),
    .en(en_vec), .set_vec(set_vec)
  );

  gpev_status #(.NPINS(NPINS), .SPLIT_A(SPLIT_A), .SPLIT_B(SPLIT_B)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .status_q(status_q), .irq_o(irq_o)
  );

  always_comb begin
    stat_pad = '0;
    stat_pad[NPINS-1:0] = status_q;
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (bus_addr == STAT_BASE + ADDR_W'(4 * w)) bus_rdata = stat_pad[w*32 +: 32];
      for (int t = 0; t < NTYPES; t++)
        if (bus_addr == en_base(t) + ADDR_W'(4 * w)) bus_rdata = en_q[t][w*32 +: 32];
    end
  end
endmodule

// File: rtl/gpev_unit_chk.sv
module gpev_unit_chk
  import gpev_pkg::*;
#(
  parameter int NPINS = 54
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_wr,
  input logic [7:0]                   bus_addr,
  input logic [NPINS-1:0]             pin_sync,
  input logic [2:0]                   irq_o,
  input logic [NPINS-1:0]             status,
  input logic [NTYPES-1:0][NPINS-1:0] en_all
);
  localparam int NWORDS = (NPINS + 31) / 32;

  logic stat_wr_any;
  assign stat_wr_any = bus_wr && (bus_addr >= STAT_BASE)
                       && (bus_addr < STAT_BASE + ADDR_W'(4 * NWORDS));

  // R7: without a status write no set bit may drop
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr_any) |-> ((status & $past(status)) == $past(status)));

  // R7/R9: an interrupt line only falls after a status write
  assert_irq_drop_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(irq_o) & ~irq_o)) |-> $past(stat_wr_any));

  // R8: a held high level survives a simultaneous clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_wr_any) |->
      ((status & $past(en_all[T_HIGH] & pin_sync)) == $past(en_all[T_HIGH] & pin_sync)));

  // R11: with every enable off no new status bit appears
  assert_quiet_when_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_all) == '0) |-> ((status & ~$past(status)) == '0));

  // R9: no line is raised while no status bit is set
  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> (irq_o == 3'b000));
endmodule

bind gpev_unit gpev_unit_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .pin_sync(pin_sync), .irq_o(irq_o), .status(status_q), .en_all(en_vec)
);

// File: tb/gpev_unit_bench.sv
`timescale 1ns/1ps
module gpev_unit_bench;
  localparam int NPINS = 54;
  localparam logic [7:0] A_ST0 = 8'h40, A_ST1 = 8'h44;
  localparam logic [7:0] A_RI0 = 8'h4C, A_RI1 = 8'h50;
  localparam logic [7:0] A_FA0 = 8'h58, A_FA1 = 8'h5C;
  localparam logic [7:0] A_HI0 = 8'h64, A_HI1 = 8'h68;
  localparam logic [7:0] A_LO0 = 8'h70, A_LO1 = 8'h74;
  localparam logic [7:0] A_AR0 = 8'h7C, A_AR1 = 8'h80;
  localparam logic [7:0] A_AF0 = 8'h88, A_AF1 = 8'h8C;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NPINS-1:0] pin_sync = '0, pin_raw = '0;
  logic [2:0] irq_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpev_unit u_gpev_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
    .pin_raw(pin_raw), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic chk_irq(input string tag, input logic [2:0] exp);
    chk(tag, {29'd0, irq_o}, {29'd0, exp});
  endtask

  task automatic t_reset();
    chk_rd("R11 reset status0", A_ST0, 0);
    chk_rd("R11 reset status1", A_ST1, 0);
    chk_rd("R11 reset rise enable", A_RI0, 0);
    chk_irq("R11 reset irq", 3'b000);
  endtask

  task automatic t_rise();
    wr(A_RI0, 32'h8);
    step(); pin_sync[3] = 1; step();
    chk_rd("R1 rise sets pin3", A_ST0, 32'h8);
    chk_irq("R9 pin3 on line0", 3'b001);
    wr(A_ST0, 32'h0);
    chk_rd("R7 zero write keeps bit", A_ST0, 32'h8);
    pin_sync[3] = 0; step();
    chk_rd("R1 fall ignored by rise enable", A_ST0, 32'h8);
    wr(A_ST0, 32'h8);
    chk_rd("R7 one write clears", A_ST0, 32'h0);
    chk_irq("R7 irq low after clear", 3'b000);
    wr(A_RI0, 0);
  endtask

  task automatic t_fall();
    wr(A_FA0, 32'h4000_0000);
    step(); pin_sync[30] = 1; step();
    chk_rd("R2 rise ignored by fall enable", A_ST0, 0);
    pin_sync[30] = 0; step();
    chk_rd("R2 fall sets pin30", A_ST0, 32'h4000_0000);
    chk_irq("R9 pin30 on line1", 3'b010);
    wr(A_ST0, 32'h4000_0000);
    wr(A_FA0, 0);
  endtask

  task automatic t_both();
    wr(A_RI1, 32'h100); wr(A_FA1, 32'h100);
    step(); pin_sync[40] = 1; step();
    chk_rd("R3 rise with both enables", A_ST1, 32'h100);
    wr(A_ST1, 32'h100);
    chk_rd("R3 cleared between edges", A_ST1, 0);
    pin_sync[40] = 0; step();
    chk_rd("R3 fall with both enables", A_ST1, 32'h100);
    wr(A_ST1, 32'h100);
    wr(A_RI1, 0); wr(A_FA1, 0);
  endtask

  task automatic t_high();
    step(); pin_sync[50] = 1;
    wr(A_HI1, 32'h4_0000);
    step();
    chk_rd("R4 high level sets pin50", A_ST1, 32'h4_0000);
    chk_irq("R9 pin50 on line2", 3'b100);
    wr(A_ST1, 32'h4_0000);
    chk_rd("R8 set wins over clear while high", A_ST1, 32'h4_0000);
    pin_sync[50] = 0; step();
    chk_rd("R4 sticky after level drops", A_ST1, 32'h4_0000);
    wr(A_ST1, 32'h4_0000);
    chk_rd("R4 clear after level gone", A_ST1, 0);
    chk_irq("R4 irq low", 3'b000);
    wr(A_HI1, 0);
  endtask

  task automatic t_low();
    wr(A_LO0, 32'h20);
    step();
    chk_rd("R5 low level sets pin5", A_ST0, 32'h20);
    pin_sync[5] = 1; step();
    wr(A_ST0, 32'h20);
    chk_rd("R5 clear once pin high", A_ST0, 0);
    wr(A_LO0, 0);
    pin_sync[5] = 0;
  endtask

  task automatic t_raw();
    wr(A_AR0, 32'h400);
    step(); pin_raw[10] = 1; step();
    chk_rd("R6 raw rise sets pin10", A_ST0, 32'h400);
    wr(A_ST0, 32'h400); wr(A_AR0, 0);
    wr(A_AF1, 32'h8000);
    step(); pin_raw[47] = 1; step();
    chk_rd("R6 raw rise ignored by raw fall", A_ST1, 0);
    pin_raw[47] = 0; step();
    chk_rd("R6 raw fall sets pin47", A_ST1, 32'h8000);
    chk_irq("R9 pin47 on line2", 3'b100);
    wr(A_ST1, 32'h8000); wr(A_AF1, 0);
  endtask

  task automatic route(input string tag, input logic [7:0] en_a, input logic [7:0] st_a,
                       input logic [31:0] bitv, input logic [2:0] exp);
    wr(en_a, bitv);
    step();
    chk_irq(tag, exp);
    wr(en_a, 0);
    wr(st_a, bitv);
    chk_irq({tag, " cleared"}, 3'b000);
  endtask

  task automatic t_route();
    pin_sync[27] = 1; pin_sync[45] = 1; pin_sync[46] = 1; pin_sync[28] = 1;
    route("R9 pin27 last of line0", A_HI0, A_ST0, 32'h0800_0000, 3'b001);
    route("R9 pin28 first of line1", A_HI0, A_ST0, 32'h1000_0000, 3'b010);
    route("R9 pin45 last of line1", A_HI1, A_ST1, 32'h0000_2000, 3'b010);
    route("R9 pin46 first of line2", A_HI1, A_ST1, 32'h0000_4000, 3'b100);
    pin_sync[27] = 0; pin_sync[45] = 0; pin_sync[46] = 0; pin_sync[28] = 0;
    step();
  endtask

  task automatic t_regs();
    wr(A_RI1, 32'hFFFF_FFFF);
    chk_rd("R10 bank1 upper bits read 0", A_RI1, 32'h003F_FFFF);
    wr(A_AF0, 32'hA5A5_A5A5);
    chk_rd("R10 raw-fall readback", A_AF0, 32'hA5A5_A5A5);
    wr(A_LO1, 32'h0000_1234);
    chk_rd("R10 low bank1 readback", A_LO1, 32'h0000_1234);
    chk_rd("R10 low bank0 untouched", A_LO0, 0);
    wr(A_RI1, 0); wr(A_AF0, 0); wr(A_LO1, 0);
  endtask

  task automatic t_quiesce();
    wr(A_HI0, 32'hFFFF_FFFF);
    step();
    foreach (u_gpev_unit.irq_o[k]) begin end
    wr(A_HI0, 0);
    wr(A_ST0, 32'hFFFF_FFFF); wr(A_ST1, 32'hFFFF_FFFF);
    chk_rd("R11 status0 empty", A_ST0, 0);
    chk_rd("R11 status1 empty", A_ST1, 0);
    chk_irq("R11 all lines low", 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_high();
    t_low();
    t_raw();
    t_route();
    t_regs();
    t_quiesce();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule